// File: doc/BRIEF.md
# SDRAM Power-Up and Command Sequencer

This block drives the command pins of an SDRAM device from reset until the memory is usable, and afterwards on request. It does nothing until software raises a start bit. It then holds the device in NOP with clock enable high for a programmable settle period. Next it issues a fixed bring-up series: precharge of every bank, a load of the mode register, and two auto-refresh commands. Each command is followed by its own quiet gap, and NOP is driven throughout each gap. When the last gap ends, a sticky done flag is raised and the bus-wait output drops.

Once the device is ready, the block serves two requests. An auto-refresh request produces one refresh and its recovery gap. A self-refresh request level puts the device into self-refresh by issuing the refresh encoding while clock enable falls. Dropping that request raises clock enable again under deselect, and the block waits out a recovery gap. A refresh request that arrives while the block is busy is latched and served as soon as the ready state is reached. The data-mask output is forced high (transfers disabled) whenever the block is busy.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is asserted, clock enable is high, chip select is high (NOP), bus_wait is high, init_done is low and every data-mask bit is high.
- R2: After reset and before init_start is seen high, only NOP is driven and bus_wait stays high, no matter how long this lasts.
- R3: Init_start sampled high at a clock edge starts a settle period of PWR_CYC cycles of NOP with clock enable high, counted from that edge.
- R4: The bring-up commands appear in a fixed order: precharge-all in the first cycle after the settle period, then mode-register load after T_RP NOP cycles, then refresh after T_RSC NOP cycles, then a second refresh after T_RC NOP cycles. Each command lasts one cycle and is always followed by NOP.
- R5: Pin encodings (cs_n, ras_n, cas_n, we_n) are as follows: precharge-all = 0,0,1,0 with addr bit 10 high and every other addr bit and ba zero; mode load = 0,0,0,0 with addr equal to mode_reg and ba zero; refresh = 0,0,0,1 with addr and ba zero; NOP = cs_n high.
- R6: init_done rises in the cycle that follows the last of the T_RC NOP cycles after the second refresh, and it then stays high. bus_wait is high in every cycle in which the block is not idle-ready, and it is always high while init_done is low.
- R7: init_start has no effect once init_done is high.
- R8: A one-cycle ref_req pulse in the ready state produces a refresh in the next cycle, followed by T_RC NOP cycles with bus_wait high, and then a return to ready.
- R9: A ref_req pulse that arrives while the block is busy is held. The refresh is issued in the cycle after the ready state is reached.
- R10: If sr_req is high in the ready state and no refresh is pending, the next cycle carries the refresh encoding with clock enable low. After that, clock enable stays low with cs_n high for as long as sr_req stays high.
- R11: When sr_req is low during self-refresh, clock enable rises in the next cycle with cs_n high. T_RC NOP cycles follow (the rising cycle counts as the first), and then the block is ready.
- R12: When a refresh and self-refresh are both wanted in the ready state, the refresh is served first, and self-refresh entry follows from the next ready cycle.
- R13: In the ready state, the data-mask bits are all low when data_en is high and all high when it is low. In every other state they are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_start | input | 1 | Software start bit for the bring-up sequence |
| mode_reg | input | ADDR_W | Value placed on addr during the mode-register load |
| ref_req | input | 1 | Auto-refresh request pulse |
| sr_req | input | 1 | Self-refresh request level |
| data_en | input | 1 | Enable for data transfer masking |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins, bit 10 is the all-bank select |
| ba | output | BA_W | Bank select |
| dqm | output | DQM_W | Data mask, high disables transfer |
| bus_wait | output | 1 | Busy indication to the internal bus |
| init_done | output | 1 | Sticky bring-up complete flag |

## Verification
The bring-up series is exercised with a non-trivial mode value and a refresh pulse injected during the settle wait. This separates correct latching of deferred refreshes from dropped ones, and it shows whether each gap is sized by its own parameter rather than a shared one. A refresh pulse on its own in the ready state shows the single-cycle response timing. A refresh pulse together with a self-refresh level shows the priority between the two and the clock-enable falling and rising edges. Repeating init_start after completion, and idling before start, show that any stray command appears as an unexpected scoreboard event.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PWR, ST_PALL, ST_GAP_RP, ST_MRS, ST_GAP_RSC,
    ST_REF1, ST_GAP_RC1, ST_REF2, ST_GAP_RC2, ST_READY,
    ST_AREF, ST_GAP_AREF, ST_SR_ENTRY, ST_SELF, ST_SR_EXIT
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_NOP, CMD_PALL, CMD_MRS, CMD_REF
  } sdram_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  function automatic cmd_pins_t encode_cmd(sdram_cmd_e c);
    cmd_pins_t p;
    case (c)
      CMD_PALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_MRS:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      CMD_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      default:  p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  sdram_cmd_e        cmd,
  input  logic [ADDR_W-1:0] mode_reg,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);

  localparam int ALLBANK_BIT = 10;

  cmd_pins_t pins;

  always_comb begin
    pins = encode_cmd(cmd);
    addr = '0;
    ba   = '0;
    case (cmd)
      CMD_PALL: addr[ALLBANK_BIT] = 1'b1;
      CMD_MRS:  addr = mode_reg;
      default:  addr = '0;
    endcase
  end

  assign cs_n  = pins.cs_n;
  assign ras_n = pins.ras_n;
  assign cas_n = pins.cas_n;
  assign we_n  = pins.we_n;

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_seq_pkg::*;
#(
  parameter int PWR_CYC = 10000,
  parameter int T_RP    = 3,
  parameter int T_RSC   = 2,
  parameter int T_RC    = 7,
  parameter int CNT_W   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_start,
  input  logic             ref_req,
  input  logic             sr_req,
  input  logic             gap_expired,
  output logic             gap_load,
  output logic [CNT_W-1:0] gap_val,
  output sdram_cmd_e       cmd,
  output logic             cke,
  output logic             bus_wait,
  output logic             init_done
);

  seq_state_e state_q, state_d;
  logic       ref_pend_q, ref_pend_d;
  logic       ref_want;
  logic       ref_taken;
  logic       done_set;

  assign ref_want = ref_req | ref_pend_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (init_start)  state_d = ST_PWR;
      ST_PWR:      if (gap_expired) state_d = ST_PALL;
      ST_PALL:                      state_d = ST_GAP_RP;
      ST_GAP_RP:   if (gap_expired) state_d = ST_MRS;
      ST_MRS:                       state_d = ST_GAP_RSC;
      ST_GAP_RSC:  if (gap_expired) state_d = ST_REF1;
      ST_REF1:                      state_d = ST_GAP_RC1;
      ST_GAP_RC1:  if (gap_expired) state_d = ST_REF2;
      ST_REF2:                      state_d = ST_GAP_RC2;
      ST_GAP_RC2:  if (gap_expired) state_d = ST_READY;
      ST_READY: begin
        if (ref_want)    state_d = ST_AREF;
        else if (sr_req) state_d = ST_SR_ENTRY;
      end
      ST_AREF:                      state_d = ST_GAP_AREF;
      ST_GAP_AREF: if (gap_expired) state_d = ST_READY;
      ST_SR_ENTRY:                  state_d = ST_SELF;
      ST_SELF:     if (!sr_req)     state_d = ST_SR_EXIT;
      ST_SR_EXIT:  if (gap_expired) state_d = ST_READY;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    gap_load = (state_d != state_q);
    case (state_d)
      ST_PWR:      gap_val = CNT_W'(PWR_CYC - 1);
      ST_GAP_RP:   gap_val = CNT_W'(T_RP - 1);
      ST_GAP_RSC:  gap_val = CNT_W'(T_RSC - 1);
      ST_GAP_RC1,
      ST_GAP_RC2,
      ST_GAP_AREF,
      ST_SR_EXIT:  gap_val = CNT_W'(T_RC - 1);
      default:     gap_val = '0;
    endcase
  end

  always_comb begin
    ref_taken  = (state_q == ST_READY) && (state_d == ST_AREF);
    ref_pend_d = (ref_pend_q | ref_req) & ~ref_taken;
    done_set   = (state_q == ST_GAP_RC2) && gap_expired;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ref_pend_q <= 1'b0;
      init_done  <= 1'b0;
    end else begin
      state_q    <= state_d;
      ref_pend_q <= ref_pend_d;
      if (done_set) init_done <= 1'b1;
    end
  end

  always_comb begin
    case (state_q)
      ST_PALL:                        cmd = CMD_PALL;
      ST_MRS:                         cmd = CMD_MRS;
      ST_REF1, ST_REF2,
      ST_AREF, ST_SR_ENTRY:           cmd = CMD_REF;
      default:                        cmd = CMD_NOP;
    endcase
    cke      = !((state_q == ST_SR_ENTRY) || (state_q == ST_SELF));
    bus_wait = (state_q != ST_READY);
  end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int PWR_CYC = 10000,
  parameter int T_RP    = 3,
  parameter int T_RSC   = 2,
  parameter int T_RC    = 7,
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int DQM_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_start,
  input  logic [ADDR_W-1:0] mode_reg,
  input  logic              ref_req,
  input  logic              sr_req,
  input  logic              data_en,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic [DQM_W-1:0]  dqm,
  output logic              bus_wait,
  output logic              init_done
);

  localparam int MAX_A   = (T_RP > T_RSC) ? T_RP : T_RSC;
  localparam int MAX_B   = (T_RC > MAX_A) ? T_RC : MAX_A;
  localparam int MAX_GAP = (PWR_CYC > MAX_B) ? PWR_CYC : MAX_B;
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  logic             rst_n_sync;
  logic             gap_load;
  logic [CNT_W-1:0] gap_val;
  logic             gap_expired;
  sdram_cmd_e       cmd;

  sdram_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  sdram_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (gap_load),
    .load_val (gap_val),
    .expired  (gap_expired)
  );

  sdram_init_fsm #(
    .PWR_CYC (PWR_CYC),
    .T_RP    (T_RP),
    .T_RSC   (T_RSC),
    .T_RC    (T_RC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .init_start  (init_start),
    .ref_req     (ref_req),
    .sr_req      (sr_req),
    .gap_expired (gap_expired),
    .gap_load    (gap_load),
    .gap_val     (gap_val),
    .cmd         (cmd),
    .cke         (cke),
    .bus_wait    (bus_wait),
    .init_done   (init_done)
  );

  sdram_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .cmd      (cmd),
    .mode_reg (mode_reg),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .addr     (addr),
    .ba       (ba)
  );

  assign dqm = (!bus_wait && data_en) ? '0 : '1;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int DQM_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [DQM_W-1:0] dqm,
  input logic             bus_wait,
  input logic             init_done
);

  a_r6_wait_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> bus_wait);

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r3_cke_high_in_bringup: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> cke);

  a_r4_nop_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> cs_n);

  a_r10_cke_fall_is_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (!cs_n && !ras_n && !cas_n && we_n));

  a_r11_cke_rise_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> cs_n);

  a_r13_mask_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> (&dqm));

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.DQM_W(DQM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .dqm       (dqm),
  .bus_wait  (bus_wait),
  .init_done (init_done)
);

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PWR  = 30;
  localparam int TRP  = 3;
  localparam int TRSC = 2;
  localparam int TRC  = 5;
  localparam int AW   = 13;
  localparam int BW   = 2;
  localparam int DW   = 2;

  localparam int EV_PALL = 1;
  localparam int EV_MRS  = 2;
  localparam int EV_REF  = 3;
  localparam int EV_SRIN = 4;
  localparam int EV_SROUT = 5;
  localparam int EV_BAD  = 9;

  typedef struct {
    int          code;
    int          at;
    logic [AW-1:0] addr;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          init_start, ref_req, sr_req, data_en;
  logic [AW-1:0] mode_reg;
  logic          cke, cs_n, ras_n, cas_n, we_n, bus_wait, init_done;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;
  logic [DW-1:0] dqm;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  exp_t q[$];
  logic cke_prev = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_cmd_seq #(
    .PWR_CYC(PWR), .T_RP(TRP), .T_RSC(TRSC), .T_RC(TRC),
    .ADDR_W(AW), .BA_W(BW), .DQM_W(DW)
  ) u_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .init_start(init_start), .mode_reg(mode_reg),
    .ref_req(ref_req), .sr_req(sr_req), .data_en(data_en),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .dqm(dqm), .bus_wait(bus_wait), .init_done(init_done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int code, input int at, input logic [AW-1:0] a, input string tag);
    exp_t e;
    e.code = code; e.at = at; e.addr = a; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // scoreboard monitor: decodes pins into command events and compares
  always @(negedge clk) begin
    int code;
    exp_t e;
    if (rst_n) begin
      code = 0;
      if (!cs_n) begin
        if (!ras_n && cas_n && !we_n)       code = EV_PALL;
        else if (!ras_n && !cas_n && !we_n) code = EV_MRS;
        else if (!ras_n && !cas_n && we_n)  code = cke ? EV_REF : EV_SRIN;
        else                                code = EV_BAD;
      end else if (cke && !cke_prev) begin
        code = EV_SROUT;
      end
      if (code != 0) begin
        if (q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R2 R7 unexpected event act=%0d exp=none (cycle %0d)", code, cyc);
        end else begin
          e = q.pop_front();
          chk({e.tag, " code"}, code, e.code);
          chk({e.tag, " cycle"}, cyc, e.at);
          chk({e.tag, " addr"}, addr, e.addr);
          chk({e.tag, " bank"}, ba, 0);
        end
      end
    end
    cke_prev = cke;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p, tp, tm, tr1, tr2, tr, n, m;
    rst_n = 1'b0; init_start = 1'b0; ref_req = 1'b0; sr_req = 1'b0;
    data_en = 1'b0; mode_reg = '0;
    repeat (4) @(negedge clk);
    chk("R1 cke", cke, 1);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 bus_wait", bus_wait, 1);
    chk("R1 init_done", init_done, 0);
    chk("R1 dqm", dqm, 2'b11);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R2 bus_wait", bus_wait, 1);
    chk("R2 init_done", init_done, 0);
    chk("R2 cs_n", cs_n, 1);

    // bring-up with a refresh pulse during the settle wait
    mode_reg = 13'h0A37;
    p   = cyc + 1;
    tp  = p + PWR;
    tm  = tp + 1 + TRP;
    tr1 = tm + 1 + TRSC;
    tr2 = tr1 + 1 + TRC;
    tr  = tr2 + 1 + TRC;
    push(EV_PALL, tp, 13'h0400, "R4 R5 pall");
    push(EV_MRS, tm, 13'h0A37, "R4 R5 mrs");
    push(EV_REF, tr1, '0, "R4 R5 ref1");
    push(EV_REF, tr2, '0, "R4 R5 ref2");
    push(EV_REF, tr + 1, '0, "R9 deferred");
    init_start = 1'b1;
    @(negedge clk); init_start = 1'b0;
    wait_to(p + 5); ref_req = 1'b1;
    @(negedge clk); ref_req = 1'b0;
    wait_to(tp - 1);
    chk("R3 cke", cke, 1);
    chk("R3 cs_n", cs_n, 1);
    wait_to(tr - 1);
    chk("R6 done early", init_done, 0);
    chk("R6 wait early", bus_wait, 1);
    wait_to(tr);
    chk("R6 done", init_done, 1);
    chk("R6 wait", bus_wait, 0);
    wait_to(tr + 1);
    chk("R9 busy", bus_wait, 1);
    wait_to(tr + 1 + TRC);
    chk("R9 gap", bus_wait, 1);
    wait_to(tr + 2 + TRC);
    chk("R9 ready", bus_wait, 0);

    // R7: start bit after completion
    init_start = 1'b1;
    @(negedge clk); init_start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 done", init_done, 1);
    chk("R7 wait", bus_wait, 0);
    chk("R7 cke", cke, 1);

    // R13: data mask
    data_en = 1'b1; #1;
    chk("R13 enabled", dqm, 2'b00);
    @(negedge clk); data_en = 1'b0; #1;
    chk("R13 disabled", dqm, 2'b11);
    @(negedge clk);

    // R8: single refresh in ready
    n = cyc;
    push(EV_REF, n + 1, '0, "R8 refresh");
    ref_req = 1'b1;
    @(negedge clk); ref_req = 1'b0;
    wait_to(n + 1 + TRC);
    chk("R8 gap", bus_wait, 1);
    wait_to(n + 2 + TRC);
    chk("R8 ready", bus_wait, 0);

    // R12 then R10/R11: refresh and self-refresh together
    n = cyc;
    push(EV_REF, n + 1, '0, "R12 first");
    push(EV_SRIN, n + 3 + TRC, '0, "R10 R12 entry");
    ref_req = 1'b1; sr_req = 1'b1;
    @(negedge clk); ref_req = 1'b0;
    wait_to(n + 3 + TRC);
    chk("R10 cke low", cke, 0);
    wait_to(n + 10 + TRC);
    chk("R10 cke held", cke, 0);
    chk("R10 deselect", cs_n, 1);
    chk("R10 busy", bus_wait, 1);
    m = cyc;
    push(EV_SROUT, m + 1, '0, "R11 exit");
    sr_req = 1'b0;
    wait_to(m + TRC);
    chk("R11 gap", bus_wait, 1);
    wait_to(m + 1 + TRC);
    chk("R11 ready", bus_wait, 0);
    chk("R11 cke", cke, 1);

    repeat (5) @(negedge clk);
    chk("R4 all events seen", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule